// File: doc/BRIEF.md
# One-Time-Programmable Row Controller

This block owns a 64-byte row that can be programmed exactly once, reached over a byte-wide, EEPROM-style write strobe bus. A three-write unlock sequence arms a programming burst. The data writes that follow land in the row at the location named by the low address bits. When the bus has been idle for a set number of cycles, the burst is closed. The controller then raises a busy flag for a fixed programming time and sets a lock bit that no later command can clear. Bytes the burst did not supply keep their blank value of FFh, and they are frozen too.

A second three-write sequence switches the block into a row-read mode. In that mode the read data output shows the row byte picked by the low six address bits, provided address bit 6 is zero. A single F0h written to any address, outside a programming burst, leaves that mode. The row and the lock bit are registers inside the block. Reset models a blank, unprogrammed part. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `otp_row_ctrl`

## Requirements
- R1: After reset every row byte reads FFh, `locked`, `busy` and `read_mode` are 0, and `rd_data` is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `read_mode`. While it is set, `rd_data` shows the row byte at index `bus_addr[5:0]` when `bus_addr[6]` is 0, and 00h when `bus_addr[6]` is 1. With `read_mode` clear, `rd_data` is 00h.
- R3: A write of F0h at any address, when no programming burst is open, clears `read_mode`.
- R4: The writes AAh@5555h, 55h@2AAAh, B0h@5555h open a programming burst. Each following write with `bus_addr[6]`=0 stores its data at index `bus_addr[5:0]`. Upper address bits are ignored, and unwritten bytes stay FFh.
- R5: A burst ends after GAP_CYCLES consecutive clock edges with no write. If it accepted at least one byte, `busy` is 1 from the next cycle for exactly PROG_CYCLES cycles, and `locked` becomes 1.
- R6: A write that arrives on the edge after GAP_CYCLES-1 idle edges still belongs to the burst.
- R7: Inside a burst, writes with `bus_addr[6]`=1 are ignored. A burst that accepts no byte leaves `busy` and `locked` at 0.
- R8: A burst accepts at most 64 bytes. Later writes in the same burst change nothing.
- R9: While `locked` is 1, the arming sequence opens no burst. No busy period follows and no byte changes.
- R10: Every write presented while `busy` is 1 is ignored, including command sequences.
- R11: A sequence write with the wrong address or data aborts the sequence. So do GAP_CYCLES idle edges between sequence writes.
- R12: Once set, `locked` never clears before reset, and no row byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 15 | Byte address for writes and row reads |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Row byte in read mode, 00h otherwise |
| read_mode | output | 1 | Row-read mode active |
| busy | output | 1 | Programming time in progress |
| locked | output | 1 | Row permanently programmed |

## Verification
Two events can fall on the same edge: the burst timeout and a fresh data write. The bench provokes this by leaving exactly GAP_CYCLES-1 idle edges after a data byte and then writing again. It judges the result by reading the later byte back as stored, and by checking that the busy period begins only after the real gap that follows. It repeats the pattern with exactly GAP_CYCLES idle edges, where the burst must already be closed. Random bursts with idle gaps just short of the limit keep meeting this boundary.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_KEY1    = 2'd1,
    SEQ_KEY2    = 2'd2,
    SEQ_CAPTURE = 2'd3
  } seq_state_e;

  localparam logic [15:0] KEY1_ADDR  = 16'h5555;
  localparam logic [15:0] KEY2_ADDR  = 16'h2AAA;
  localparam logic [7:0]  KEY1_DATA  = 8'hAA;
  localparam logic [7:0]  KEY2_DATA  = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hB0;
  localparam logic [7:0]  CMD_READ   = 8'h90;
  localparam logic [7:0]  CMD_RETURN = 8'hF0;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int ROW_BYTES  = 64,
  parameter int GAP_CYCLES = 16,
  localparam int IDX_W     = $clog2(ROW_BYTES),
  localparam int CNT_W     = $clog2(ROW_BYTES + 1),
  localparam int GAP_W     = $clog2(GAP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              locked_i,
  input  logic              busy_i,
  output logic              cap_we_o,
  output logic [IDX_W-1:0]  cap_idx_o,
  output logic [7:0]        cap_data_o,
  output logic              commit_o,
  output logic              rd_mode_o
);
  seq_state_e       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_mode_q, rd_mode_d;
  logic             acc, gap_hit, at_key1, at_key2, is_return;

  assign acc       = we_i && !busy_i;
  assign gap_hit   = (gap_q == GAP_W'(GAP_CYCLES - 1));
  assign at_key1   = (addr_i == ADDR_W'(KEY1_ADDR));
  assign at_key2   = (addr_i == ADDR_W'(KEY2_ADDR));
  assign is_return = (wdata_i == CMD_RETURN);

  assign cap_idx_o  = addr_i[IDX_W-1:0];
  assign cap_data_o = wdata_i;
  assign rd_mode_o  = rd_mode_q;

  always_comb begin
    state_d   = state_q;
    gap_d     = gap_q;
    cnt_d     = cnt_q;
    rd_mode_d = rd_mode_q;
    cap_we_o  = 1'b0;
    commit_o  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (acc) begin
          if (is_return) begin
            rd_mode_d = 1'b0;
          end else if (at_key1 && wdata_i == KEY1_DATA) begin
            state_d = SEQ_KEY1;
            gap_d   = '0;
          end
        end
      end
      SEQ_KEY1: begin
        if (acc) begin
          gap_d = '0;
          if (at_key2 && wdata_i == KEY2_DATA) begin
            state_d = SEQ_KEY2;
          end else begin
            state_d = SEQ_IDLE;
            if (is_return) rd_mode_d = 1'b0;
          end
        end else if (gap_hit) begin
          state_d = SEQ_IDLE;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      SEQ_KEY2: begin
        if (acc) begin
          gap_d   = '0;
          state_d = SEQ_IDLE;
          if (at_key1 && wdata_i == CMD_PROG && !locked_i) begin
            state_d = SEQ_CAPTURE;
            cnt_d   = '0;
          end else if (at_key1 && wdata_i == CMD_READ) begin
            rd_mode_d = 1'b1;
          end else if (is_return) begin
            rd_mode_d = 1'b0;
          end
        end else if (gap_hit) begin
          state_d = SEQ_IDLE;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      SEQ_CAPTURE: begin
        if (acc) begin
          gap_d = '0;
          if (!addr_i[IDX_W] && cnt_q < CNT_W'(ROW_BYTES)) begin
            cap_we_o = 1'b1;
            cnt_d    = cnt_q + CNT_W'(1);
          end
        end else if (gap_hit) begin
          state_d  = SEQ_IDLE;
          commit_o = (cnt_q != '0);
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      gap_q     <= '0;
      cnt_q     <= '0;
      rd_mode_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      gap_q     <= gap_d;
      cnt_q     <= cnt_d;
      rd_mode_q <= rd_mode_d;
    end
  end

  assert_byte_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ROW_BYTES));
  assert_mode_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_mode_q) |-> $past(we_i && wdata_i == CMD_RETURN));
  assert_idle_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(rd_mode_q));
endmodule

// File: rtl/otp_row_store.sv
module otp_row_store
  import otp_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  localparam int IDX_W    = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_we_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic [7:0]       cap_data_i,
  input  logic             commit_i,
  input  logic             rd_en_i,
  input  logic [IDX_W:0]   rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             locked_o
);
  logic [ROW_BYTES-1:0][7:0] row_q, row_d;
  logic                      row_en;
  logic                      locked_q, locked_d;

  assign row_en   = cap_we_i && !locked_q;
  assign locked_d = locked_q | commit_i;
  assign locked_o = locked_q;

  always_comb begin
    row_d = row_q;
    row_d[cap_idx_i] = cap_data_i;
  end

  assign rd_data_o = (rd_en_i && !rd_addr_i[IDX_W]) ? row_q[rd_addr_i[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= {ROW_BYTES{BLANK_BYTE}};
    end else if (row_en) begin
      row_q <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked_q));
  assert_row_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_q) |-> $stable(row_q));
  assert_no_capture_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we_i |-> !locked_q);
endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int PROG_CYCLES = 40,
  localparam int TMR_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  output logic busy_o
);
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (commit_i)          tmr_d = TMR_W'(PROG_CYCLES);
    else if (tmr_q != '0)  tmr_d = tmr_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign busy_o = (tmr_q != '0);

  assert_commit_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !busy_o);
  assert_busy_follows_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> busy_o);
endmodule

// File: rtl/otp_row_ctrl.sv
module otp_row_ctrl #(
  parameter int ADDR_W      = 15,
  parameter int ROW_BYTES   = 64,
  parameter int GAP_CYCLES  = 16,
  parameter int PROG_CYCLES = 40,
  localparam int IDX_W      = $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              read_mode,
  output logic              busy,
  output logic              locked
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cap_we, commit;
  logic [IDX_W-1:0] cap_idx;
  logic [7:0]       cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  otp_cmd_decode #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .GAP_CYCLES(GAP_CYCLES)
  ) u_decode (
    .clk(clk), .rst_n(rst_int_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .locked_i(locked), .busy_i(busy),
    .cap_we_o(cap_we), .cap_idx_o(cap_idx), .cap_data_o(cap_data),
    .commit_o(commit), .rd_mode_o(read_mode)
  );

  otp_row_store #(.ROW_BYTES(ROW_BYTES)) u_store (
    .clk(clk), .rst_n(rst_int_n), .cap_we_i(cap_we), .cap_idx_i(cap_idx),
    .cap_data_i(cap_data), .commit_i(commit), .rd_en_i(read_mode),
    .rd_addr_i(bus_addr[IDX_W:0]), .rd_data_o(rd_data), .locked_o(locked)
  );

  otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .commit_i(commit), .busy_o(busy)
  );
endmodule

// File: tb/otp_row_ctrl_bench.sv
module otp_row_ctrl_bench;
  localparam int G = 16;
  localparam int P = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        read_mode, busy, locked;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_row [64];

  always #5 clk = ~clk;

  otp_row_ctrl u_otp_row_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .read_mode(read_mode),
    .busy(busy), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    bus_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    for (int i = 0; i < 64; i++) exp_row[i] = 8'hFF;
  endtask

  task automatic arm();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hB0);
  endtask

  task automatic enter_read();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
  endtask

  function automatic logic [7:0] rd_model(input logic [14:0] a, input logic mode);
    if (!mode || a[6]) return 8'h00;
    return exp_row[a[5:0]];
  endfunction

  task automatic rd_chk(input string req, input logic [14:0] a);
    bus_addr = a;
    #1;
    chk(req, rd_data, rd_model(a, read_mode));
  endtask

  task automatic wait_busy_done();
    while (busy) @(negedge clk);
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd9157));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 locked", locked, 0);
    chk("R1 read_mode", read_mode, 0);
    bus_addr = 15'h0003; #1; chk("R1 rd_data", rd_data, 8'h00);

    // R2 read mode
    enter_read();
    chk("R2 read_mode", read_mode, 1);
    rd_chk("R2 blank byte", 15'h0005);
    bus_addr = 15'h0045; #1; chk("R2 A6 high", rd_data, 8'h00);

    // R3 return
    wr(15'h1234, 8'hF0);
    chk("R3 read_mode", read_mode, 0);
    bus_addr = 15'h0005; #1; chk("R3 rd_data", rd_data, 8'h00);

    // R11 aborts
    wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'h90);
    chk("R11 wrong addr", read_mode, 0);
    wr(15'h5555, 8'hAA); idle(G); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
    chk("R11 gap timeout", read_mode, 0);

    // R7 burst with only A6=1 writes
    arm(); wr(15'h0043, 8'h11); idle(G);
    chk("R7 no busy", busy, 0); chk("R7 no lock", locked, 0);

    // R4 R6 R5 main burst
    arm();
    wr(15'h7F02, 8'h12); exp_row[2] = 8'h12;
    idle(G - 1);
    wr(15'h0007, 8'h34); exp_row[7] = 8'h34;   // R6 write on timeout edge
    wr(15'h0049, 8'h56);                        // R7 ignored
    idle(G);
    chk("R5 busy on", busy, 1); chk("R5 locked", locked, 1);
    enter_read();                               // R10 ignored while busy
    idle(P - 4);
    chk("R5 busy still", busy, 1);
    idle(1);
    chk("R5 busy off", busy, 0);
    chk("R10 read_mode", read_mode, 0);
    enter_read();
    rd_chk("R4 byte 2", 15'h0002);
    rd_chk("R6 byte 7", 15'h0007);
    rd_chk("R7 byte 9", 15'h0009);
    rd_chk("R4 byte 0", 15'h0000);

    // R9 R12 locked
    arm(); wr(15'h0002, 8'h99); idle(G);
    chk("R9 no busy", busy, 0);
    rd_chk("R9 byte 2", 15'h0002);
    chk("R12 locked", locked, 1);

    // R8 byte limit
    do_reset();
    arm();
    for (int i = 0; i < 64; i++) begin
      wr(15'(i), 8'(i) ^ 8'h5A); exp_row[i] = 8'(i) ^ 8'h5A;
    end
    wr(15'h0000, 8'hC3);
    idle(G); wait_busy_done();
    enter_read();
    rd_chk("R8 byte 0", 15'h0000);
    rd_chk("R8 byte 63", 15'h003F);

    // random bursts
    for (int t = 0; t < 20; t++) begin
      int n, cnt;
      do_reset();
      if ($urandom_range(0, 1) == 1) enter_read();
      arm();
      n = $urandom_range(1, 70);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
        logic [14:0] a;
        logic [7:0]  d;
        a = 15'($urandom);
        if ($urandom_range(0, 3) != 0) a[6] = 1'b0;
        d = 8'($urandom);
        wr(a, d);
        if (!a[6] && cnt < 64) begin
          exp_row[a[5:0]] = d; cnt++;
        end
        if ($urandom_range(0, 3) == 0) idle(G - 1);
        else idle($urandom_range(0, G - 2));
      end
      idle(G - ((n > 0) ? 0 : 0));
      chk("R5 random busy", busy, (cnt > 0) ? 1 : 0);
      chk("R7 random lock", locked, (cnt > 0) ? 1 : 0);
      wait_busy_done();
      enter_read();
      for (int i = 0; i < 64; i++) rd_chk("R4 random byte", 15'(i) | 15'h3F00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule